// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block forms the word a host sees when it reads a flash device while a program or erase runs internally. The command decoder tells it when an operation starts, of which kind, and the word being programmed. It also signals completion, an internal time-limit overrun, an aborted buffer load, the close of the erase window, and erase suspend. For each read strobe the block returns either the array data, or a status word. That status word carries a polling bit, two toggle bits, a time-limit flag, an erase-window flag and an abort flag.

Each read is captured on the rising edge of the read strobe and held until the next one. The two toggle bits advance once per captured read, not once per clock. This lets host software find out whether the device is busy by comparing two successive reads. When the operation finishes, busy falls and later reads return array data again.

Top module: `flash_op_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), busy is 0 and rd_data is all zeros, including when the reset lands in the middle of an operation.
- R2: A read is captured only at the first clock edge of a rising read strobe; holding the strobe high neither recaptures rd_data nor advances a toggle bit.
- R3: With busy low, a read returns array_data unchanged on all bits.
- R4: During word program (op_kind 0) or buffer program (op_kind 2), bit 7 reads as the inverse of bit 7 of the programmed word.
- R5: During erase (op_kind 1), bit 7 reads 0; while erase is suspended, a read of an erase-involved sector returns 1 on bit 7.
- R6: Bit 6 reads 0 on the first status read after op_start and inverts on every later status read, while the operation is not an erase in suspend.
- R7: After timeout_evt, bit 5 reads 1 until the operation ends.
- R8: After abort_evt during buffer program, bit 1 reads 1 until the operation ends; abort_evt during other kinds has no effect.
- R9: During erase, bit 3 reads 0 until window_evt, then 1; it is 0 for program kinds.
- R10: Bit 2 reads 0 on the first erase-sector read of an erase and inverts only on reads with sector_hit high. Reads without sector_hit show it unchanged; it stays 0 for program kinds.
- R11: While an erase is suspended, a read with sector_hit low returns array_data, and bit 6 keeps its value across suspended reads.
- R12: busy rises at the clock edge that samples op_start and falls at the edge that samples op_done. The next read returns array_data.
- R13: In a status word, bits 0, 4 and every bit above 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start | input | 1 | One-cycle pulse: an embedded operation begins |
| op_kind | input | 2 | 0 word program, 1 erase, 2 buffer program |
| op_data | input | DW | Word being programmed (bit 7 used for polling) |
| op_done | input | 1 | One-cycle pulse: operation completed |
| timeout_evt | input | 1 | Pulse: internal time limit exceeded |
| abort_evt | input | 1 | Pulse: buffer load aborted |
| window_evt | input | 1 | Pulse: erase sector-add window closed |
| suspend | input | 1 | Level: erase is suspended |
| sector_hit | input | 1 | Read address lies in a sector being erased |
| rd_strobe | input | 1 | Read strobe (output enable), sampled on clk |
| array_data | input | DW | Data from the memory array |
| rd_data | output | DW | Captured read result |
| busy | output | 1 | High for the whole embedded operation |

## Verification
The bench builds the block with DW = 16. That way the upper byte of a status word can be seen, and it must stay zero, while idle and suspended reads must pass the full 16-bit array value. The word 0x1280 has bit 7 set among other bits, so it is used to show that polling depends only on bit 7. Its programmed word 0x0001 gives the opposite polling value. Erase reads alternate sector_hit so that the two toggle bits drift apart, which shows that each advances on its own condition.

// File: rtl/flash_status_pkg.sv
// Shared types and status bit positions for the operation status generator.
// Assumes a data width of at least 8 bits at every user.
package flash_status_pkg;
    typedef enum logic [1:0] {
        OP_WORD_PGM = 2'd0,
        OP_ERASE    = 2'd1,
        OP_BUF_PGM  = 2'd2
    } op_kind_e;

    // Bit positions are fixed because host polling software decodes them.
    localparam int BIT_POLL = 7;
    localparam int BIT_TOG  = 6;
    localparam int BIT_TMO  = 5;
    localparam int BIT_WIN  = 3;
    localparam int BIT_ESEC = 2;
    localparam int BIT_ABT  = 1;
endpackage

// File: rtl/fs_strobe_edge.sv
// Rising-edge detector for the read strobe.
// Assumes the strobe is already synchronous to clk and is high for at least one cycle.
module fs_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;

    // R2: a rise cannot repeat on two consecutive cycles.
    p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/fs_op_tracker.sv
// Tracks one embedded operation: busy window, kind, polling bit and sticky flags.
// Assumes op_start, op_done and the event inputs are single-cycle pulses.
// op_start wins over op_done in the same cycle.
module fs_op_tracker
    import flash_status_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_start,
    input  op_kind_e op_kind,
    input  logic [DW-1:0] op_data,
    input  logic     op_done,
    input  logic     timeout_evt,
    input  logic     abort_evt,
    input  logic     window_evt,
    output logic     busy,
    output op_kind_e kind_q,
    output logic     poll_bit,
    output logic     tmo_flag,
    output logic     abt_flag,
    output logic     win_flag
);
    // Busy window and operation descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            kind_q   <= OP_WORD_PGM;
            poll_bit <= 1'b0;
        end else if (op_start) begin
            busy     <= 1'b1;
            kind_q   <= op_kind;
            poll_bit <= op_data[BIT_POLL];
        end else if (op_done) begin
            busy     <= 1'b0;
        end
    end

    // Sticky condition flags, cleared when an operation begins or ends.
    always_ff @(posedge clk) begin
        if (!rst_n || op_start || op_done) begin
            tmo_flag <= 1'b0;
            abt_flag <= 1'b0;
            win_flag <= 1'b0;
        end else if (busy) begin
            if (timeout_evt)                          tmo_flag <= 1'b1;
            if (abort_evt && kind_q == OP_BUF_PGM)    abt_flag <= 1'b1;
            if (window_evt && kind_q == OP_ERASE)     win_flag <= 1'b1;
        end
    end

    // R8: the abort flag only exists inside a buffer program.
    p_abort_buffer_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abt_flag |-> (busy && kind_q == OP_BUF_PGM));
    // R7: the time-limit flag never outlives the operation.
    p_tmo_within_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |-> busy);
    // R9: the window flag only exists inside an erase.
    p_window_erase_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_flag |-> (busy && kind_q == OP_ERASE));
    // R12: completion drops busy at the next edge.
    p_busy_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !op_start) |=> !busy);
    // R12: start raises busy at the next edge.
    p_busy_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> busy);
endmodule

// File: rtl/fs_toggle_cell.sv
// One toggle status bit: cleared at operation start, inverted on each qualifying read.
// Assumes clear and step are sampled on the same edge, with clear taking priority.
module fs_toggle_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic q
);
    // Hold, clear or invert the toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) q <= 1'b0;
        else if (step)       q <= ~q;
    end

    // R6, R10: a qualifying read always changes the bit seen by the next read.
    p_toggle_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (q != $past(q)));
    // R10: without a step or clear the bit is frozen.
    p_toggle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(q));
endmodule

// File: rtl/flash_op_status.sv
// Top of the status generator. On each read strobe rise it captures either array
// data or the status word into rd_data and advances the toggle bits.
// Assumes DW >= 8 and inputs synchronous to clk.
module flash_op_status
    import flash_status_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic [1:0]    op_kind,
    input  logic [DW-1:0] op_data,
    input  logic          op_done,
    input  logic          timeout_evt,
    input  logic          abort_evt,
    input  logic          window_evt,
    input  logic          suspend,
    input  logic          sector_hit,
    input  logic          rd_strobe,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data,
    output logic          busy
);
    localparam int NTOG = 2;   // index 0: bit 6 toggle, index 1: bit 2 toggle

    logic     rise;
    op_kind_e kind_q;
    logic     poll_bit, tmo_flag, abt_flag, win_flag;
    logic     is_erase, erase_susp, pass_array;
    logic [NTOG-1:0] tog_step, tog_q;
    logic [DW-1:0]   status_word, read_word;

    fs_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rd_strobe),
        .rise   (rise)
    );

    fs_op_tracker #(.DW(DW)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_start    (op_start),
        .op_kind     (op_kind_e'(op_kind)),
        .op_data     (op_data),
        .op_done     (op_done),
        .timeout_evt (timeout_evt),
        .abort_evt   (abort_evt),
        .window_evt  (window_evt),
        .busy        (busy),
        .kind_q      (kind_q),
        .poll_bit    (poll_bit),
        .tmo_flag    (tmo_flag),
        .abt_flag    (abt_flag),
        .win_flag    (win_flag)
    );

    // Operation context used by the read path.
    always_comb begin
        is_erase   = busy && (kind_q == OP_ERASE);
        erase_susp = is_erase && suspend;
        pass_array = !busy || (erase_susp && !sector_hit);
    end

    // Toggle qualifiers: bit 6 on any status read outside suspend, bit 2 on erase-sector reads.
    always_comb begin
        tog_step[0] = rise && !pass_array && !erase_susp;
        tog_step[1] = rise && !pass_array && is_erase && sector_hit;
    end

    for (genvar g = 0; g < NTOG; g++) begin : g_tog
        fs_toggle_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (op_start),
            .step  (tog_step[g]),
            .q     (tog_q[g])
        );
    end

    // Assemble the status word; unused bits stay zero.
    always_comb begin
        status_word           = '0;
        status_word[BIT_POLL] = is_erase ? erase_susp : ~poll_bit;
        status_word[BIT_TOG]  = tog_q[0];
        status_word[BIT_TMO]  = tmo_flag;
        status_word[BIT_WIN]  = is_erase && win_flag;
        status_word[BIT_ESEC] = is_erase && tog_q[1];
        status_word[BIT_ABT]  = abt_flag;
        read_word             = pass_array ? array_data : status_word;
    end

    // Capture one read result per strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n)    rd_data <= '0;
        else if (rise) rd_data <= read_word;
    end

    // R3: idle reads return the array word.
    p_idle_array_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !busy) |=> (rd_data == $past(array_data)));
    // R13: reserved low bits of a status word read zero.
    p_reserved_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !pass_array) |=> (rd_data[0] == 1'b0 && rd_data[4] == 1'b0));
    // R2: without a strobe rise the captured word holds.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(rd_data));
    // R5: an erase in progress and not suspended never reports bit 7 set.
    p_erase_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && is_erase && !suspend) |=> !rd_data[BIT_POLL]);
endmodule

// File: tb/tb_flash_op_status.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module tb_flash_op_status;
    localparam int DW = 16;
    localparam int NV = 36;

    // Fields: [42:40] action, [39:38] kind, [37] sector_hit, [36:21] arg,
    //         [20:5] expected rd_data, [4] expected busy, [3:0] requirement.
    // Actions: 0 read, 1 start, 2 done, 3 timeout, 4 abort, 5 window, 6 suspend on, 7 suspend off.
    localparam logic [42:0] VEC [NV] = '{
        {3'd1, 2'd0, 1'b0, 16'h1280, 16'h0000, 1'b1, 4'd0},
        {3'd0, 2'd0, 1'b0, 16'hBEEF, 16'h0000, 1'b1, 4'd4},   // R4 inverse of bit 7
        {3'd0, 2'd0, 1'b0, 16'hBEEF, 16'h0040, 1'b1, 4'd6},   // R6
        {3'd0, 2'd0, 1'b1, 16'hBEEF, 16'h0000, 1'b1, 4'd10},  // R10 no DQ2 in program
        {3'd3, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd0},
        {3'd0, 2'd0, 1'b0, 16'hBEEF, 16'h0060, 1'b1, 4'd7},   // R7
        {3'd4, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd0},
        {3'd0, 2'd0, 1'b0, 16'hBEEF, 16'h0020, 1'b1, 4'd8},   // R8 abort ignored
        {3'd2, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd0},
        {3'd0, 2'd0, 1'b0, 16'hBEEF, 16'hBEEF, 1'b0, 4'd3},   // R3
        {3'd1, 2'd0, 1'b0, 16'h0001, 16'h0000, 1'b1, 4'd0},
        {3'd0, 2'd0, 1'b0, 16'hBEEF, 16'h0080, 1'b1, 4'd4},   // R4
        {3'd0, 2'd0, 1'b0, 16'hBEEF, 16'h00C0, 1'b1, 4'd6},   // R6
        {3'd2, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd0},
        {3'd0, 2'd0, 1'b0, 16'h1234, 16'h1234, 1'b0, 4'd12},  // R12
        {3'd1, 2'd2, 1'b0, 16'h00FF, 16'h0000, 1'b1, 4'd0},
        {3'd0, 2'd0, 1'b0, 16'hBEEF, 16'h0000, 1'b1, 4'd4},   // R4 buffer
        {3'd4, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd0},
        {3'd0, 2'd0, 1'b0, 16'hBEEF, 16'h0042, 1'b1, 4'd8},   // R8
        {3'd0, 2'd0, 1'b0, 16'hBEEF, 16'h0002, 1'b1, 4'd13},  // R13
        {3'd2, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd0},
        {3'd0, 2'd0, 1'b0, 16'h5A5A, 16'h5A5A, 1'b0, 4'd3},   // R3
        {3'd1, 2'd1, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd0},
        {3'd0, 2'd0, 1'b1, 16'hBEEF, 16'h0000, 1'b1, 4'd5},   // R5
        {3'd0, 2'd0, 1'b0, 16'hBEEF, 16'h0044, 1'b1, 4'd10},  // R10
        {3'd5, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd0},
        {3'd0, 2'd0, 1'b1, 16'hBEEF, 16'h000C, 1'b1, 4'd9},   // R9
        {3'd0, 2'd0, 1'b1, 16'hBEEF, 16'h0048, 1'b1, 4'd10},  // R10
        {3'd6, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd0},
        {3'd0, 2'd0, 1'b1, 16'h7777, 16'h008C, 1'b1, 4'd5},   // R5 suspended
        {3'd0, 2'd0, 1'b0, 16'h7777, 16'h7777, 1'b1, 4'd11},  // R11
        {3'd0, 2'd0, 1'b1, 16'h7777, 16'h0088, 1'b1, 4'd11},  // R11 DQ6 held
        {3'd7, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd0},
        {3'd0, 2'd0, 1'b1, 16'hBEEF, 16'h000C, 1'b1, 4'd6},   // R6 resumed
        {3'd2, 2'd0, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd0},
        {3'd0, 2'd0, 1'b0, 16'h0F0F, 16'h0F0F, 1'b0, 4'd3}    // R3
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0, op_done = 1'b0;
    logic [1:0]    op_kind = 2'd0;
    logic [DW-1:0] op_data = '0, array_data = '0;
    logic          timeout_evt = 1'b0, abort_evt = 1'b0, window_evt = 1'b0;
    logic          suspend = 1'b0, sector_hit = 1'b0, rd_strobe = 1'b0;
    logic [DW-1:0] rd_data;
    logic          busy;
    int            checks = 0, errors = 0;
    logic          finished = 1'b0;

    always #5 clk = ~clk;

    flash_op_status #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_data(op_data), .op_done(op_done), .timeout_evt(timeout_evt),
        .abort_evt(abort_evt), .window_evt(window_evt), .suspend(suspend),
        .sector_hit(sector_hit), .rd_strobe(rd_strobe), .array_data(array_data),
        .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input int req, input logic [DW-1:0] exp_d, input logic exp_b);
        checks++;
        if (rd_data !== exp_d || busy !== exp_b) begin
            errors++;
            $display("FAIL R%0d: rd_data=%h busy=%b expected rd_data=%h busy=%b",
                     req, rd_data, busy, exp_d, exp_b);
        end
    endtask

    task automatic do_read(input logic hit, input logic [DW-1:0] arr);
        @(negedge clk);
        rd_strobe = 1'b1; sector_hit = hit; array_data = arr;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic do_action(input logic [2:0] act, input logic [1:0] kind, input logic [DW-1:0] arg);
        @(negedge clk);
        case (act)
            3'd1: begin op_start = 1'b1; op_kind = kind; op_data = arg; end
            3'd2: op_done = 1'b1;
            3'd3: timeout_evt = 1'b1;
            3'd4: abort_evt = 1'b1;
            3'd5: window_evt = 1'b1;
            3'd6: suspend = 1'b1;
            3'd7: suspend = 1'b0;
            default: ;
        endcase
        @(negedge clk);
        op_start = 1'b0; op_done = 1'b0; timeout_evt = 1'b0;
        abort_evt = 1'b0; window_evt = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, '0, 1'b0);                       // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][42:40] == 3'd0) begin
                do_read(VEC[i][37], VEC[i][36:21]);
                check(int'(VEC[i][3:0]), VEC[i][20:5], VEC[i][4]);
            end else begin
                do_action(VEC[i][42:40], VEC[i][39:38], VEC[i][36:21]);
            end
        end

        // R12: busy is high right after the edge that samples op_start.
        @(negedge clk);
        op_start = 1'b1; op_kind = 2'd0; op_data = 16'h0000;
        @(negedge clk);
        op_start = 1'b0;
        check(12, 16'h0F0F, 1'b1);

        // R2: a held strobe captures once and does not advance the toggle.
        @(negedge clk);
        rd_strobe = 1'b1; array_data = 16'hAAAA;
        @(negedge clk);
        check(2, 16'h0080, 1'b1);
        @(negedge clk);
        check(2, 16'h0080, 1'b1);
        rd_strobe = 1'b0;
        do_read(1'b0, 16'hAAAA);
        check(2, 16'h00C0, 1'b1);

        // R1: reset in the middle of an operation.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, '0, 1'b0);
        rst_n = 1'b1;
        do_read(1'b0, 16'h3C3C);
        check(3, 16'h3C3C, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule